// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface and walks the memory from power-up to normal operation. After reset it holds the clock enable low and leaves the chip deselected. It then waits for a start strobe that says supplies, reference voltage and clock have settled. Next it counts out a stabilization wait whose length follows from the clock frequency and a microsecond figure. When the wait ends it raises the clock enable with a NOP and plays a fixed bring-up script on the command and address pins. Between commands it inserts NOP cycles until each minimum spacing is met.

The script runs as follows. First a precharge of all banks. Then an extended mode load that turns the DLL on. Then a base mode load that resets the DLL and sets the operating fields. Then a second precharge of all banks, followed by two auto refreshes. Last comes a base mode load with the DLL reset bit cleared, after which an init-done flag is raised. A separate read permit goes high a fixed number of cycles after the DLL-reset load. Later logic uses this permit to keep reads off the bus until the DLL has locked.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is asserted, and afterwards until start is sampled high, the block drives cke low, deselect on the command pins ({cs_n,ras_n,cas_n,we_n} = 1111), ba and addr at zero, and both init_done and read_allowed low.
- R2: Once start is sampled high on a clock edge, cke stays low for exactly WAIT_CYC = CLK_MHZ*WAIT_US cycles. cke then rises in the same cycle that a NOP is driven.
- R3: Commands use the encoding {cs_n,ras_n,cas_n,we_n}: NOP 0111, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000, deselect 1111. Deselect occurs only while cke is low.
- R4: After the opening NOP the commands come in this order: PRECHARGE, LOAD MODE (extended), LOAD MODE (DLL reset), PRECHARGE, AUTO REFRESH, AUTO REFRESH, LOAD MODE (run).
- R5: The address fields are as follows. PRECHARGE drives addr bit 10 high, all other addr bits 0, and ba 00. The extended load drives ba 01 and addr EMR_VAL. The DLL-reset load drives ba 00 and addr MR_VAL with bit DLL_RST_BIT (8) set. The run load drives ba 00 and addr MR_VAL with bit 8 cleared. NOP and AUTO REFRESH drive ba and addr at zero.
- R6: Each command lasts one cycle, and NOPs fill every gap. The spacing to the next command is exactly 1 cycle after the opening NOP, T_RP after a PRECHARGE, T_MRD after a LOAD MODE and T_RFC after an AUTO REFRESH. All three spacings are at least 2.
- R7: read_allowed rises exactly DLL_CYC cycles after the cycle that carries the DLL-reset load. It then stays high until reset.
- R8: init_done rises exactly T_MRD cycles after the run load and stays high. From then on the pins carry NOP with cke high.
- R9: Once cke is high it stays high until reset.
- R10: Start pulses or a held-high start after the first accepted start have no effect on the pins, on read_allowed or on init_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Supplies and clock are stable; begin the bring-up |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| read_allowed | output | 1 | High once the DLL lock interval after the DLL reset has passed |
| init_done | output | 1 | High once the whole script has completed |

## Verification
The read permit and the completion flag come from separate counters, and they can rise on the same clock edge. The bench picks T_RP=4, T_MRD=2 and T_RFC=96, so the span from the DLL-reset load to init_done equals the 200-cycle DLL interval. Both flags are therefore due in one cycle. Every cycle of several runs is compared against a timeline worked out arithmetically in the bench. An explicit check then confirms that both flags first appear at the computed edge, with neither early nor late. The runs vary the idle time, add stray start pulses, hold start high throughout, and abort with a reset.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111,
    CMD_DES = 4'b1111
  } ddr_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_GAP,
    ST_DONE
  } seq_state_e;

  localparam int unsigned SCRIPT_LEN = 7;
  localparam int unsigned STEP_W     = 3;

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/ddr_init_script.sv
module ddr_init_script
  import ddr_init_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned BA_W        = 2,
  parameter int unsigned CW          = 16,
  parameter int unsigned T_RP        = 3,
  parameter int unsigned T_MRD       = 2,
  parameter int unsigned T_RFC       = 15,
  parameter int unsigned EMR_VAL     = 0,
  parameter int unsigned MR_VAL      = 'h032,
  parameter int unsigned DLL_RST_BIT = 8,
  parameter int unsigned A10_BIT     = 10
) (
  input  logic [STEP_W-1:0] step,
  output ddr_cmd_e          cmd,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic [CW-1:0]     gap_load,
  output logic              dll_rst
);

  localparam logic [ADDR_W-1:0] DLL_MASK = ADDR_W'(1) << DLL_RST_BIT;
  localparam logic [ADDR_W-1:0] ALL_BANK = ADDR_W'(1) << A10_BIT;
  localparam logic [ADDR_W-1:0] MR_BASE  = ADDR_W'(MR_VAL);
  localparam logic [CW-1:0]     RP_LD    = CW'(T_RP - 1);
  localparam logic [CW-1:0]     MRD_LD   = CW'(T_MRD - 1);
  localparam logic [CW-1:0]     RFC_LD   = CW'(T_RFC - 1);

  always_comb begin
    cmd      = CMD_NOP;
    ba       = '0;
    addr     = '0;
    gap_load = '0;
    dll_rst  = 1'b0;
    case (step)
      3'd0, 3'd3: begin
        cmd      = CMD_PRE;
        addr     = ALL_BANK;
        gap_load = RP_LD;
      end
      3'd1: begin
        cmd      = CMD_LMR;
        ba       = BA_W'(1);
        addr     = ADDR_W'(EMR_VAL);
        gap_load = MRD_LD;
      end
      3'd2: begin
        cmd      = CMD_LMR;
        addr     = MR_BASE | DLL_MASK;
        gap_load = MRD_LD;
        dll_rst  = 1'b1;
      end
      3'd4, 3'd5: begin
        cmd      = CMD_REF;
        gap_load = RFC_LD;
      end
      3'd6: begin
        cmd      = CMD_LMR;
        addr     = MR_BASE & ~DLL_MASK;
        gap_load = MRD_LD;
      end
      default: begin
        cmd = CMD_NOP;
      end
    endcase
  end

endmodule

// File: rtl/ddr_init_dll_guard.sv
module ddr_init_dll_guard #(
  parameter int unsigned DLL_CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic allowed
);

  localparam int unsigned GW = $clog2(DLL_CYC + 1);

  logic [GW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      allowed <= 1'b0;
    end else if (arm) begin
      cnt_q <= GW'(DLL_CYC - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        allowed <= 1'b1;
        run_q   <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ     = 200,
  parameter int unsigned WAIT_US     = 200,
  parameter int unsigned T_RP        = 3,
  parameter int unsigned T_MRD       = 2,
  parameter int unsigned T_RFC       = 15,
  parameter int unsigned DLL_CYC     = 200,
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned BA_W        = 2,
  parameter int unsigned EMR_VAL     = 0,
  parameter int unsigned MR_VAL      = 'h032,
  parameter int unsigned DLL_RST_BIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              read_allowed,
  output logic              init_done
);

  localparam int unsigned WAIT_CYC = CLK_MHZ * WAIT_US;
  localparam int unsigned G1       = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int unsigned GMAX     = (G1 > T_RFC) ? G1 : T_RFC;
  localparam int unsigned TMAX     = (WAIT_CYC > GMAX) ? WAIT_CYC : GMAX;
  localparam int unsigned CW       = $clog2(TMAX + 1);

  seq_state_e          state_q;
  logic [STEP_W-1:0]   step_q;
  ddr_cmd_e            cmd_q;
  logic                cke_q;
  logic [BA_W-1:0]     ba_q;
  logic [ADDR_W-1:0]   addr_q;
  logic                done_q;

  logic                t_load;
  logic [CW-1:0]       t_val;
  logic                t_zero;
  logic                issue;
  logic                step_end;

  ddr_cmd_e            s_cmd;
  logic [BA_W-1:0]     s_ba;
  logic [ADDR_W-1:0]   s_addr;
  logic [CW-1:0]       s_gap;
  logic                s_dll;

  ddr_init_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  ddr_init_script #(
    .ADDR_W      (ADDR_W),
    .BA_W        (BA_W),
    .CW          (CW),
    .T_RP        (T_RP),
    .T_MRD       (T_MRD),
    .T_RFC       (T_RFC),
    .EMR_VAL     (EMR_VAL),
    .MR_VAL      (MR_VAL),
    .DLL_RST_BIT (DLL_RST_BIT),
    .A10_BIT     (10)
  ) u_script (
    .step     (step_q),
    .cmd      (s_cmd),
    .ba       (s_ba),
    .addr     (s_addr),
    .gap_load (s_gap),
    .dll_rst  (s_dll)
  );

  ddr_init_dll_guard #(.DLL_CYC(DLL_CYC)) u_guard (
    .clk     (clk),
    .rst     (rst),
    .arm     (issue && s_dll),
    .allowed (read_allowed)
  );

  assign step_end = (step_q == STEP_W'(SCRIPT_LEN));

  // Timer control: the wait, the single-cycle NOP slot, and each command gap
  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    issue  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          t_load = 1'b1;
          t_val  = CW'(WAIT_CYC - 1);
        end
      end
      ST_WAIT: begin
        if (t_zero) begin
          t_load = 1'b1;
          t_val  = '0;
        end
      end
      ST_GAP: begin
        if (t_zero && !step_end) begin
          issue  = 1'b1;
          t_load = 1'b1;
          t_val  = s_gap;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      cmd_q   <= CMD_DES;
      cke_q   <= 1'b0;
      ba_q    <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          cmd_q <= CMD_DES;
          if (start) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (t_zero) begin
            cmd_q   <= CMD_NOP;
            cke_q   <= 1'b1;
            state_q <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (issue) begin
            cmd_q  <= s_cmd;
            ba_q   <= s_ba;
            addr_q <= s_addr;
            step_q <= step_q + 1'b1;
          end else begin
            cmd_q  <= CMD_NOP;
            ba_q   <= '0;
            addr_q <= '0;
            if (t_zero && step_end) begin
              done_q  <= 1'b1;
              state_q <= ST_DONE;
            end
          end
        end
        ST_DONE: begin
          cmd_q  <= CMD_NOP;
          ba_q   <= '0;
          addr_q <= '0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign cke       = cke_q;
  assign ba        = ba_q;
  assign addr      = addr_q;
  assign init_done = done_q;

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BA_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              read_allowed,
  input logic              init_done
);

  logic is_nop, is_pre, is_cmd;
  assign is_nop = !cs_n && ras_n && cas_n && we_n;
  assign is_pre = !cs_n && !ras_n && cas_n && !we_n;
  assign is_cmd = !cs_n && !(ras_n && cas_n && we_n);

  // R1: first cycle after reset shows the reset state
  a_r1_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cke && cs_n && !init_done && !read_allowed));

  // R2: clock enable rises together with a NOP
  a_r2_cke_with_nop: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> is_nop);

  // R3: deselect drives all strobes high and only while cke is low
  a_r3_deselect: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (ras_n && cas_n && we_n && !cke));

  // R5: precharge always targets all banks
  a_r5_pre_all: assert property (@(posedge clk) disable iff (rst)
    is_pre |-> (addr[10] && ba == '0));

  // R6: a command occupies one cycle and is followed by a NOP
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
    is_cmd |=> is_nop);

  // R7: read permit holds once given
  a_r7_permit_hold: assert property (@(posedge clk) disable iff (rst)
    read_allowed |=> read_allowed);

  // R8: completion holds and the bus idles with NOP
  a_r8_done_hold: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (cke && is_nop));

  // R9: clock enable never drops outside reset
  a_r9_cke_hold: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);

endmodule

bind ddr_init_seq ddr_init_seq_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cke          (cke),
  .cs_n         (cs_n),
  .ras_n        (ras_n),
  .cas_n        (cas_n),
  .we_n         (we_n),
  .ba           (ba),
  .addr         (addr),
  .read_allowed (read_allowed),
  .init_done    (init_done)
);

// File: tb/ddr_init_seq_test.sv
module ddr_init_seq_test;

  localparam int W    = 20;   // CLK_MHZ=1, WAIT_US=20
  localparam int TRP  = 4;
  localparam int TMRD = 2;
  localparam int TRFC = 96;
  localparam int DLL  = 200;
  localparam int MRV  = 'h032;
  localparam int EMRV = 0;

  // expected timeline, cycles after the edge that accepts start
  localparam int TN  = W;
  localparam int TP1 = TN + 1;
  localparam int TE  = TP1 + TRP;
  localparam int TM  = TE + TMRD;
  localparam int TP2 = TM + TMRD;
  localparam int TR1 = TP2 + TRP;
  localparam int TR2 = TR1 + TRFC;
  localparam int TF  = TR2 + TRFC;
  localparam int TD  = TF + TMRD;
  localparam int TRA = TM + DLL;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        cke, cs_n, ras_n, cas_n, we_n, read_allowed, init_done;
  logic [1:0]  ba;
  logic [12:0] addr;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #2.5 clk = ~clk;

  ddr_init_seq #(
    .CLK_MHZ (1), .WAIT_US (W), .T_RP (TRP), .T_MRD (TMRD), .T_RFC (TRFC),
    .DLL_CYC (DLL), .ADDR_W (13), .BA_W (2), .EMR_VAL (EMRV),
    .MR_VAL (MRV), .DLL_RST_BIT (8)
  ) uut (
    .clk (clk), .rst (rst), .start (start), .cke (cke), .cs_n (cs_n),
    .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .ba (ba), .addr (addr),
    .read_allowed (read_allowed), .init_done (init_done)
  );

  // {cke, cs,ras,cas,we, ba, addr, read_allowed, init_done}
  localparam logic [21:0] RESET_VEC = {1'b0, 4'b1111, 2'b00, 13'h0, 1'b0, 1'b0};

  function automatic logic [21:0] expect_at(input int k);
    logic [3:0]  c;
    logic [1:0]  b;
    logic [12:0] a;
    c = 4'b0111; b = 2'b00; a = 13'h0;
    if (k < TN)                     c = 4'b1111;
    else if (k == TP1 || k == TP2) begin c = 4'b0010; a = 13'h400; end
    else if (k == TE)               begin c = 4'b0000; b = 2'b01; a = 13'(EMRV); end
    else if (k == TM)               begin c = 4'b0000; a = 13'(MRV) | 13'h100; end
    else if (k == TR1 || k == TR2)  c = 4'b0001;
    else if (k == TF)               begin c = 4'b0000; a = 13'(MRV) & ~13'h100; end
    return {k >= TN, c, b, a, k >= TRA, k >= TD};
  endfunction

  function automatic logic [21:0] observed();
    return {cke, cs_n, ras_n, cas_n, we_n, ba, addr, read_allowed, init_done};
  endfunction

  task automatic check(input string req, input logic [21:0] got, input logic [21:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic string tag_for(input logic [21:0] got, input logic [21:0] exp);
    if (got[21] !== exp[21])           return "R2 R9 cke";
    if (got[20:17] !== exp[20:17])     return "R3 R4 R6 command";
    if (got[16:2] !== exp[16:2])       return "R5 address";
    if (got[1] !== exp[1])             return "R7 read_allowed";
    if (got[0] !== exp[0])             return "R8 init_done";
    return "R4 R6";
  endfunction

  task automatic run(input int idle, input bit poke, input bit hold, input bit abort);
    logic [21:0] e;
    rst = 1'b1; start = 1'b0;
    @(negedge clk);
    check("R1 in reset", observed(), RESET_VEC);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", observed(), RESET_VEC);
    for (int i = 0; i < idle; i++) begin
      @(negedge clk);
      check("R1 idle", observed(), RESET_VEC);
    end
    start = 1'b1;
    @(negedge clk);
    start = hold;
    for (int k = 1; k <= TD + 4; k++) begin
      @(negedge clk);
      e = expect_at(k);
      check(tag_for(observed(), e), observed(), e);
      if (k == TD) begin
        // R7 R8: both flags first appear at this same edge
        checks++;
        if (!(read_allowed && init_done) || TRA != TD) begin
          fails++;
          $display("FAIL R7 R8 coincidence: got ra=%b done=%b expected 1 1", read_allowed, init_done);
        end
      end
      if (abort && k == 60) begin
        rst = 1'b1;
        @(negedge clk);
        check("R1 R9 abort reset", observed(), RESET_VEC);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after abort", observed(), RESET_VEC);
        return;
      end
      // R10: stray start activity must not disturb the timeline
      start = hold || (poke && (k == 50 || k == TR2 + 3 || k == TD + 1));
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    run(0, 1'b0, 1'b0, 1'b0);   // R2 R4 R5 R6 R7 R8 baseline
    run(7, 1'b1, 1'b0, 1'b0);   // R10 stray start pulses
    run(3, 1'b0, 1'b1, 1'b0);   // R10 start held high
    run(2, 1'b0, 1'b0, 1'b1);   // R1 R9 reset mid-sequence
    run(1, 1'b0, 1'b0, 1'b0);   // clean run after the abort
    ended = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule